// File: doc/BRIEF.md
# Register Rename Map with Reader Counting

This block renames register specifiers for an in-order instruction stream, accepting at most one instruction per clock. An instruction names up to two source registers and an optional destination register out of 8 architectural registers. The sources are looked up in a map table, and the result is the physical register (one of 16) that holds the newest value of each. Each granted destination receives a new physical register from the head of a free-list FIFO, and the map entry is redirected to it. Because of this, repeated writes to one architectural register never share storage. Write-after-read and write-after-write conflicts are removed, and read-after-write links are kept.

Each physical register has a count of readers that have not finished yet. Renaming a source adds one to the count of the physical register it resolves to. A reader-done pulse that names a physical tag subtracts one. A physical register goes back to the free list only when two things are true: a newer write has displaced it from the map, and its count is zero. That can happen at the moment of displacement, or later when its last reader finishes. When the free list is empty, an instruction that has a destination is held off with a stall.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i resolves to physical register i for every i in 0..7.
- R2: Sources are resolved combinationally through the map as it stands before the same instruction's destination update, so a source that names the instruction's own destination returns the previous mapping.
- R3: After reset the free list holds physical tags 8..15 in ascending order. A granted destination takes the head entry, and released tags are appended at the tail (FIFO order).
- R4: A granted destination is mapped to its new physical register from the next cycle on, and that register differs from every register currently mapped. Repeated writes to one architectural register therefore get distinct physical registers.
- R5: When a granted write displaces a physical register whose reader count is zero after that cycle, the displaced register is appended to the free list in the same cycle.
- R6: Each renamed source adds one to its register's reader count, so a register named as both sources gets two. A reader-done pulse subtracts one. A displaced register is freed in the cycle its count drops to zero, and not earlier.
- R7: When a displacement release and a reader-done release fall in the same cycle, both tags are appended, the lower tag first.
- R8: If a valid request has a destination while the free list is empty, stall is 1 and grant is 0, and the map and the free list are left unchanged.
- R9: A request without a destination is granted even when the free list is empty. Stall is 0 whenever no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | Rename request present |
| src0Valid | input | 1 | First source is used |
| src0Arch | input | 3 | First source architectural register |
| src1Valid | input | 1 | Second source is used |
| src1Arch | input | 3 | Second source architectural register |
| dstValid | input | 1 | Instruction writes a destination |
| dstArch | input | 3 | Destination architectural register |
| doneValid | input | 1 | A reader has finished with a physical register |
| doneTag | input | 4 | Physical register whose reader finished |
| renGrant | output | 1 | Request accepted this cycle |
| stall | output | 1 | Request held off for lack of a free register |
| src0Phys | output | 4 | Physical register for the first source |
| src1Phys | output | 4 | Physical register for the second source |
| dstPhys | output | 4 | Physical register given to the destination (free-list head) |

## Verification
Two things can collide in one clock. A granted write may displace a register that has no readers, while a reader-done pulse brings a different, already displaced register to zero readers. Both tags must then be appended in ascending order. The bench sets this up so that the done tag is lower than the displaced tag, which exposes any fixed priority. It then makes eight back-to-back allocations and compares the returned tags with the expected FIFO order. A second collision is a done pulse arriving while the list is empty and a write is stalled. The bench checks that the stalled write leaves the map untouched, and that the tag freed by the pulse is the one handed out next.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int ARCH_REGS = 8;
  localparam int PHYS_REGS = 16;
  localparam int ARCH_W = $clog2(ARCH_REGS);
  localparam int PHYS_W = $clog2(PHYS_REGS);
  localparam int CNT_W = 4;

  typedef struct packed {
    logic rename;
    logic alloc;
    logic pushOld;
    logic pushDone;
  } renStrobe_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
(
  input  logic       renValid,
  input  logic       dstValid,
  input  logic       freeEmpty,
  input  logic       oldZero,
  input  logic       doneRelease,
  output logic       renGrant,
  output logic       stall,
  output renStrobe_t strobe
);
  logic needReg;

  always_comb begin
    needReg = renValid && dstValid;
    stall = needReg && freeEmpty;
    renGrant = renValid && !stall;
    strobe.rename = renGrant;
    strobe.alloc = renGrant && dstValid;
    strobe.pushOld = renGrant && dstValid && oldZero;
    strobe.pushDone = doneRelease;
  end
endmodule

// File: rtl/rename_dp.sv
module rename_dp
  import rename_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  renStrobe_t        strobe,
  input  logic              src0Valid,
  input  logic [ARCH_W-1:0] src0Arch,
  input  logic              src1Valid,
  input  logic [ARCH_W-1:0] src1Arch,
  input  logic [ARCH_W-1:0] dstArch,
  input  logic              doneValid,
  input  logic [PHYS_W-1:0] doneTag,
  output logic [PHYS_W-1:0] src0Phys,
  output logic [PHYS_W-1:0] src1Phys,
  output logic [PHYS_W-1:0] dstPhys,
  output logic              freeEmpty,
  output logic              oldZero,
  output logic              doneRelease
);
  localparam int FREE_INIT = PHYS_REGS - ARCH_REGS;

  logic [PHYS_W-1:0] mapTab [ARCH_REGS];
  logic [CNT_W-1:0]  readers [PHYS_REGS];
  logic [PHYS_REGS-1:0] displaced;
  logic [PHYS_W-1:0] freeFifo [PHYS_REGS];
  logic [PHYS_W-1:0] headPtr, tailPtr;
  logic [PHYS_W:0]   freeCnt;

  logic [PHYS_W-1:0] oldPhys;
  logic [CNT_W-1:0]  oldNext;
  logic [PHYS_W-1:0] pushLo, pushHi;

  always_comb begin
    src0Phys = mapTab[src0Arch];
    src1Phys = mapTab[src1Arch];
    oldPhys = mapTab[dstArch];
    dstPhys = freeFifo[headPtr];
    freeEmpty = (freeCnt == '0);
    oldNext = readers[oldPhys]
            + CNT_W'(src0Valid && src0Phys == oldPhys)
            + CNT_W'(src1Valid && src1Phys == oldPhys)
            - CNT_W'(doneValid && doneTag == oldPhys && readers[oldPhys] != '0);
    oldZero = (oldNext == '0);
    doneRelease = doneValid && displaced[doneTag] && readers[doneTag] == CNT_W'(1);
    pushLo = (doneTag < oldPhys) ? doneTag : oldPhys;
    pushHi = (doneTag < oldPhys) ? oldPhys : doneTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < ARCH_REGS; a++) mapTab[a] <= PHYS_W'(a);
    end else if (strobe.alloc) begin
      mapTab[dstArch] <= dstPhys;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PHYS_REGS; p++) readers[p] <= '0;
      displaced <= '0;
    end else begin
      for (int p = 0; p < PHYS_REGS; p++) begin
        readers[p] <= readers[p]
          + CNT_W'(strobe.rename && src0Valid && src0Phys == PHYS_W'(p))
          + CNT_W'(strobe.rename && src1Valid && src1Phys == PHYS_W'(p))
          - CNT_W'(doneValid && doneTag == PHYS_W'(p) && readers[p] != '0);
      end
      if (strobe.alloc) begin
        displaced[dstPhys] <= 1'b0;
        displaced[oldPhys] <= !strobe.pushOld;
      end
      if (strobe.pushDone) displaced[doneTag] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS_REGS; i++)
        freeFifo[i] <= (i < FREE_INIT) ? PHYS_W'(ARCH_REGS + i) : '0;
      headPtr <= '0;
      tailPtr <= PHYS_W'(FREE_INIT);
      freeCnt <= (PHYS_W+1)'(FREE_INIT);
    end else begin
      if (strobe.pushOld && strobe.pushDone) begin
        freeFifo[tailPtr] <= pushLo;
        freeFifo[tailPtr + PHYS_W'(1)] <= pushHi;
      end else if (strobe.pushOld) begin
        freeFifo[tailPtr] <= oldPhys;
      end else if (strobe.pushDone) begin
        freeFifo[tailPtr] <= doneTag;
      end
      tailPtr <= tailPtr + PHYS_W'(strobe.pushOld) + PHYS_W'(strobe.pushDone);
      headPtr <= headPtr + PHYS_W'(strobe.alloc);
      freeCnt <= freeCnt + (PHYS_W+1)'(strobe.pushOld) + (PHYS_W+1)'(strobe.pushDone)
               - (PHYS_W+1)'(strobe.alloc);
    end
  end
endmodule

// File: rtl/rename_map.sv
module rename_map
  import rename_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              renValid,
  input  logic              src0Valid,
  input  logic [ARCH_W-1:0] src0Arch,
  input  logic              src1Valid,
  input  logic [ARCH_W-1:0] src1Arch,
  input  logic              dstValid,
  input  logic [ARCH_W-1:0] dstArch,
  input  logic              doneValid,
  input  logic [PHYS_W-1:0] doneTag,
  output logic              renGrant,
  output logic              stall,
  output logic [PHYS_W-1:0] src0Phys,
  output logic [PHYS_W-1:0] src1Phys,
  output logic [PHYS_W-1:0] dstPhys
);
  renStrobe_t strobe;
  logic freeEmpty, oldZero, doneRelease;

  rename_ctrl u_ctrl (
    .renValid(renValid), .dstValid(dstValid), .freeEmpty(freeEmpty),
    .oldZero(oldZero), .doneRelease(doneRelease),
    .renGrant(renGrant), .stall(stall), .strobe(strobe)
  );

  rename_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .src0Valid(src0Valid), .src0Arch(src0Arch),
    .src1Valid(src1Valid), .src1Arch(src1Arch),
    .dstArch(dstArch), .doneValid(doneValid), .doneTag(doneTag),
    .src0Phys(src0Phys), .src1Phys(src1Phys), .dstPhys(dstPhys),
    .freeEmpty(freeEmpty), .oldZero(oldZero), .doneRelease(doneRelease)
  );
endmodule

// File: rtl/rename_map_chk.sv
module rename_map_chk
  import rename_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              renValid,
  input logic              src0Valid,
  input logic [ARCH_W-1:0] src0Arch,
  input logic              dstValid,
  input logic [ARCH_W-1:0] dstArch,
  input logic              renGrant,
  input logic              stall,
  input logic [PHYS_W-1:0] src0Phys,
  input logic [PHYS_W-1:0] dstPhys
);
  p_grant_or_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(renGrant && stall));

  p_stall_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (renValid && dstValid));

  p_nodst_granted_r9: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && !dstValid) |-> renGrant);

  p_fresh_dst_r4: assert property (@(posedge clk) disable iff (!rstN)
    (renGrant && dstValid && src0Valid) |-> (dstPhys != src0Phys));

  p_newest_seen_r2: assert property (@(posedge clk) disable iff (!rstN)
    (renGrant && dstValid) |=>
      ((src0Arch == $past(dstArch)) -> (src0Phys == $past(dstPhys))));
endmodule

bind rename_map rename_map_chk u_chk (
  .clk(clk), .rstN(rstN), .renValid(renValid),
  .src0Valid(src0Valid), .src0Arch(src0Arch),
  .dstValid(dstValid), .dstArch(dstArch),
  .renGrant(renGrant), .stall(stall),
  .src0Phys(src0Phys), .dstPhys(dstPhys)
);

// File: tb/rename_map_bench.sv
module rename_map_bench;
  logic clk = 0;
  logic rstN = 0;
  logic renValid = 0, src0Valid = 0, src1Valid = 0, dstValid = 0, doneValid = 0;
  logic [2:0] src0Arch = 0, src1Arch = 0, dstArch = 0;
  logic [3:0] doneTag = 0;
  logic renGrant, stall;
  logic [3:0] src0Phys, src1Phys, dstPhys;

  int checks = 0;
  int errors = 0;
  logic gGrant, gStall;
  logic [3:0] gS0, gS1, gDst;

  always #10 clk = ~clk;

  rename_map u_rename_map (
    .clk(clk), .rstN(rstN), .renValid(renValid),
    .src0Valid(src0Valid), .src0Arch(src0Arch),
    .src1Valid(src1Valid), .src1Arch(src1Arch),
    .dstValid(dstValid), .dstArch(dstArch),
    .doneValid(doneValid), .doneTag(doneTag),
    .renGrant(renGrant), .stall(stall),
    .src0Phys(src0Phys), .src1Phys(src1Phys), .dstPhys(dstPhys)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, sample, commit at the rising edge.
  task automatic issue(input logic v, input logic s0v, input int s0, input logic s1v,
                       input int s1, input logic dv, input int d,
                       input logic donev, input int dtag);
    @(negedge clk);
    renValid = v; src0Valid = s0v; src0Arch = 3'(s0); src1Valid = s1v; src1Arch = 3'(s1);
    dstValid = dv; dstArch = 3'(d); doneValid = donev; doneTag = 4'(dtag);
    #2;
    gGrant = renGrant; gStall = stall; gS0 = src0Phys; gS1 = src1Phys; gDst = dstPhys;
    @(posedge clk);
    #1;
    renValid = 0; src0Valid = 0; src1Valid = 0; dstValid = 0; doneValid = 0;
  endtask

  task automatic done(input int tag);
    issue(0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9 stall idle", stall, 0);
    issue(1, 1, 3, 1, 5, 0, 0, 0, 0);
    chk("R1 src0 r3", gS0, 3);
    chk("R1 src1 r5", gS1, 5);
    chk("R9 grant nodst", gGrant, 1);
    done(3);
    done(5);
  endtask

  task automatic t_raw_waw;
    issue(1, 1, 1, 0, 0, 1, 1, 0, 0);
    chk("R2 src old map", gS0, 1);
    chk("R3 first alloc", gDst, 8);
    issue(1, 1, 1, 0, 0, 1, 1, 0, 0);
    chk("R4 newest seen", gS0, 8);
    chk("R4 distinct dst", gDst, 9);
    done(1);
    done(8);
  endtask

  task automatic t_dual_release;
    issue(1, 1, 2, 0, 0, 1, 2, 0, 0);
    chk("R3 alloc 10", gDst, 10);
    issue(1, 0, 0, 0, 0, 1, 1, 1, 2);
    chk("R5 alloc 11", gDst, 11);
    begin
      int expSeq[8] = '{12, 13, 14, 15, 1, 8, 2, 9};
      for (int i = 0; i < 8; i++) begin
        issue(1, 0, 0, 0, 0, 1, 0, 0, 0);
        chk("R7 R6 R5 fifo order", gDst, expSeq[i]);
      end
    end
  endtask

  task automatic t_stall;
    begin
      int expDst[8] = '{0, 12, 13, 14, 15, 1, 8, 2};
      int expSrc[8] = '{9, 11, 10, 3, 4, 5, 6, 7};
      for (int k = 0; k < 8; k++) begin
        issue(1, 1, k, 0, 0, 1, k, 0, 0);
        chk("R6 held src", gS0, expSrc[k]);
        chk("R6 held dst", gDst, expDst[k]);
      end
    end
    issue(1, 1, 0, 0, 0, 1, 3, 0, 0);
    chk("R8 stall", gStall, 1);
    chk("R8 no grant", gGrant, 0);
    issue(1, 1, 3, 0, 0, 0, 0, 0, 0);
    chk("R8 map kept", gS0, 14);
    chk("R9 grant empty", gGrant, 1);
    chk("R9 no stall", gStall, 0);
    done(9);
    issue(1, 0, 0, 0, 0, 1, 3, 0, 0);
    chk("R6 freed by done", gDst, 9);
    chk("R8 grant after free", gGrant, 1);
  endtask

  task automatic t_double_read;
    issue(1, 1, 5, 1, 5, 0, 0, 0, 0);
    chk("R6 both src", gS0 + 16 * gS1, 1 + 16 * 1);
    done(5);
    issue(1, 0, 0, 0, 0, 1, 5, 0, 0);
    chk("R6 alloc 5", gDst, 5);
    done(1);
    issue(1, 0, 0, 0, 0, 1, 6, 0, 0);
    chk("R6 one reader left", gStall, 1);
    done(1);
    issue(1, 0, 0, 0, 0, 1, 6, 0, 0);
    chk("R6 second done frees", gDst, 1);
    chk("R6 grant", gGrant, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_raw_waw();
    t_dual_release();
    t_stall();
    t_double_read();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule